// File: doc/BRIEF.md
# Host Bridge Configuration Access Port

This block is the processor-facing front end for configuration cycles in a host bridge. Software sees four word-sized registers: a target-select register naming the bus, device, function and dword register of the next configuration cycle; a data window that turns each access into a downstream configuration read or write; a control register whose bit 0 picks the byte order of all register traffic; and a flush register that returns a fixed pattern.

Accesses to the data window are enabled by the top bit of the target-select register. When they are enabled, the block raises a request toward the configuration fabric and holds it under a valid/ready handshake. The processor side is held off until that request completes. A read response is returned one cycle after the fabric answers.

When control bit 0 is clear, every value written is byte-reversed before use, and every value read is byte-reversed before it is returned. When the bit is set, no reversal is done.

Top module: `cfg_access_port`

## Requirements
- R1: A write to the target-select register (word offset 0) keeps only the bits selected by 0x80fffffc of the (possibly byte-reversed) write value; a read returns the stored value.
- R2: After reset the target-select register reads 0, control bit 0 is 0, cpu_ready is 1, and cpu_rvalid and dn_valid are 0.
- R3: With control bit 0 clear, write data is byte-reversed before it is stored or forwarded, and read data is byte-reversed before it is returned. With the bit set, no reversal is done. The control register (word offset 2) stores bit 0 only and reads 0 in bits 31:1.
- R4: A read of the data window (word offset 1) while target-select bit 31 is clear returns 0xffffffff and starts no downstream access.
- R5: A write to the data window while target-select bit 31 is clear is dropped: no downstream access starts and the configuration contents stay unchanged.
- R6: A downstream request carries dn_bus = target bits 23:16, dn_dev = bits 15:11, dn_fn = bits 10:8 and dn_reg = bits 7:2, and dn_wdata is the data-window write value after R3.
- R7: dn_valid stays high, with all request fields stable, until dn_ready. cpu_ready is low while it waits. A read response (cpu_rvalid with dn_rdata) appears in the cycle after the handshake.
- R8: A read of the flush register (word offset 3) returns 0xc000ffee, subject to R3. Writes to it have no effect.
- R9: A request is accepted in a cycle where cpu_req and cpu_ready are both high. A read of a local register gives cpu_rvalid in the next cycle. A downstream request starts only from an accepted data-window access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Processor register access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | CPU_AW | Register word offset |
| cpu_wdata | input | 32 | Write data as seen on the processor bus |
| cpu_ready | output | 1 | Block can accept a request |
| cpu_rvalid | output | 1 | Read response valid |
| cpu_rdata | output | 32 | Read response data |
| dn_valid | output | 1 | Downstream configuration request valid |
| dn_we | output | 1 | Downstream request is a write |
| dn_bus | output | 8 | Target bus number |
| dn_dev | output | 5 | Target device number |
| dn_fn | output | 3 | Target function number |
| dn_reg | output | 6 | Target dword register index |
| dn_wdata | output | 32 | Downstream write data |
| dn_ready | input | 1 | Downstream request accepted and completed |
| dn_rdata | input | 32 | Downstream read data, valid with dn_ready |

## Verification
The assertions assume that the configuration fabric raises dn_ready only while dn_valid is high. They also assume that the processor ignores cpu_rvalid except after a read it issued. The bench's fabric model raises dn_ready for exactly one cycle, a set number of cycles after it sees dn_valid. The processor tasks drive cpu_req only on a falling edge where cpu_ready is high, and they wait for each read's response before the next access.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    localparam int unsigned WORD_W = 32;

    // register word offsets (decoded by the top)
    localparam int unsigned OFS_TARGET = 0;
    localparam int unsigned OFS_WINDOW = 1;
    localparam int unsigned OFS_CTRL   = 2;
    localparam int unsigned OFS_FLUSH  = 3;

    typedef enum logic [0:0] {
        PH_IDLE = 1'b0,
        PH_FABRIC = 1'b1
    } phase_e;

    typedef struct packed {
        logic [WORD_W-1:0] target;
        logic              order_native;
        phase_e            phase;
        logic              req_write;
        logic [WORD_W-1:0] wdata;
        logic [WORD_W-1:0] rdata;
        logic              rvalid;
    } port_state_t;

endpackage

// File: rtl/cfg_byte_swap.sv
module cfg_byte_swap #(
    parameter int unsigned W = 32
) (
    input  logic         swap_en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int unsigned NBYTES = W / 8;

    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assign dout[8*b +: 8] = swap_en ? din[8*(NBYTES-1-b) +: 8] : din[8*b +: 8];
    end
endmodule

// File: rtl/cfg_target_split.sv
module cfg_target_split #(
    parameter int unsigned W     = 32,
    parameter int unsigned BUS_W = 8,
    parameter int unsigned DEV_W = 5,
    parameter int unsigned FN_W  = 3,
    parameter int unsigned REG_W = 6
) (
    input  logic [W-1:0]     target,
    output logic [BUS_W-1:0] bus,
    output logic [DEV_W-1:0] dev,
    output logic [FN_W-1:0]  fn,
    output logic [REG_W-1:0] regi
);
    localparam int unsigned REG_LO = 2;
    localparam int unsigned FN_LO  = REG_LO + REG_W;
    localparam int unsigned DEV_LO = FN_LO + FN_W;
    localparam int unsigned BUS_LO = DEV_LO + DEV_W;

    assign regi = target[REG_LO +: REG_W];
    assign fn   = target[FN_LO  +: FN_W];
    assign dev  = target[DEV_LO +: DEV_W];
    assign bus  = target[BUS_LO +: BUS_W];
endmodule

// File: rtl/cfg_access_port.sv
module cfg_access_port
    import cfg_pkg::*;
#(
    parameter int unsigned        CPU_AW      = 2,
    parameter logic [WORD_W-1:0]  TARGET_MASK = 32'h80ff_fffc,
    parameter logic [WORD_W-1:0]  FLUSH_VALUE = 32'hc000_ffee
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [31:0]       cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_rvalid,
    output logic [31:0]       cpu_rdata,
    output logic              dn_valid,
    output logic              dn_we,
    output logic [7:0]        dn_bus,
    output logic [4:0]        dn_dev,
    output logic [2:0]        dn_fn,
    output logic [5:0]        dn_reg,
    output logic [31:0]       dn_wdata,
    input  logic              dn_ready,
    input  logic [31:0]       dn_rdata
);
    localparam logic [CPU_AW-1:0] A_TARGET = CPU_AW'(OFS_TARGET);
    localparam logic [CPU_AW-1:0] A_WINDOW = CPU_AW'(OFS_WINDOW);
    localparam logic [CPU_AW-1:0] A_CTRL   = CPU_AW'(OFS_CTRL);
    localparam logic [CPU_AW-1:0] A_FLUSH  = CPU_AW'(OFS_FLUSH);
    localparam int unsigned       EN_BIT   = WORD_W - 1;

    port_state_t s_d, s_q;

    logic              swap_en;
    logic              accept;
    logic              cfg_en;
    logic [WORD_W-1:0] wr_val;

    assign swap_en = ~s_q.order_native;
    assign cfg_en  = s_q.target[EN_BIT];
    assign accept  = cpu_req && (s_q.phase == PH_IDLE);

    cfg_byte_swap #(.W(WORD_W)) u_wr_swap (
        .swap_en (swap_en),
        .din     (cpu_wdata),
        .dout    (wr_val)
    );

    cfg_byte_swap #(.W(WORD_W)) u_rd_swap (
        .swap_en (swap_en),
        .din     (s_q.rdata),
        .dout    (cpu_rdata)
    );

    cfg_target_split #(.W(WORD_W)) u_split (
        .target (s_q.target),
        .bus    (dn_bus),
        .dev    (dn_dev),
        .fn     (dn_fn),
        .regi   (dn_reg)
    );

    always_comb begin
        s_d        = s_q;
        s_d.rvalid = 1'b0;

        if (accept) begin
            case (cpu_addr)
                A_TARGET: begin
                    if (cpu_we) begin
                        s_d.target = wr_val & TARGET_MASK;
                    end else begin
                        s_d.rdata  = s_q.target;
                        s_d.rvalid = 1'b1;
                    end
                end
                A_WINDOW: begin
                    if (cfg_en) begin
                        s_d.phase     = PH_FABRIC;
                        s_d.req_write = cpu_we;
                        s_d.wdata     = wr_val;
                    end else if (!cpu_we) begin
                        s_d.rdata  = '1;
                        s_d.rvalid = 1'b1;
                    end
                end
                A_CTRL: begin
                    if (cpu_we) begin
                        s_d.order_native = wr_val[0];
                    end else begin
                        s_d.rdata  = {{(WORD_W-1){1'b0}}, s_q.order_native};
                        s_d.rvalid = 1'b1;
                    end
                end
                A_FLUSH: begin
                    if (!cpu_we) begin
                        s_d.rdata  = FLUSH_VALUE;
                        s_d.rvalid = 1'b1;
                    end
                end
                default: ;
            endcase
        end

        if (s_q.phase == PH_FABRIC && dn_ready) begin
            s_d.phase = PH_IDLE;
            if (!s_q.req_write) begin
                s_d.rdata  = dn_rdata;
                s_d.rvalid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{target: '0, order_native: 1'b0, phase: PH_IDLE,
                     req_write: 1'b0, wdata: '0, rdata: '0, rvalid: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign cpu_ready  = (s_q.phase == PH_IDLE);
    assign cpu_rvalid = s_q.rvalid;
    assign dn_valid   = (s_q.phase == PH_FABRIC);
    assign dn_we      = s_q.req_write;
    assign dn_wdata   = s_q.wdata;

endmodule

// File: rtl/cfg_access_port_chk.sv
module cfg_access_port_chk #(
    parameter int unsigned CPU_AW = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic [CPU_AW-1:0] cpu_addr,
    input logic              cpu_ready,
    input logic              cpu_rvalid,
    input logic              dn_valid,
    input logic              dn_we,
    input logic [7:0]        dn_bus,
    input logic [4:0]        dn_dev,
    input logic [2:0]        dn_fn,
    input logic [5:0]        dn_reg,
    input logic [31:0]       dn_wdata,
    input logic              dn_ready,
    input logic              cfg_en
);
    localparam logic [CPU_AW-1:0] WIN = CPU_AW'(cfg_pkg::OFS_WINDOW);

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid && !dn_ready |=> dn_valid &&
            $stable({dn_we, dn_bus, dn_dev, dn_fn, dn_reg, dn_wdata}));

    assert_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> !cpu_ready);

    // R4 / R5: no downstream traffic while the enable bit is clear
    assert_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> cfg_en);

    assert_launch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dn_valid) |-> $past(cpu_req && cpu_ready && cpu_addr == WIN));

    assert_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rvalid |-> $past((cpu_req && cpu_ready && !cpu_we) ||
                             (dn_valid && dn_ready && !dn_we)));
endmodule

bind cfg_access_port cfg_access_port_chk #(.CPU_AW(CPU_AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_addr   (cpu_addr),
    .cpu_ready  (cpu_ready),
    .cpu_rvalid (cpu_rvalid),
    .dn_valid   (dn_valid),
    .dn_we      (dn_we),
    .dn_bus     (dn_bus),
    .dn_dev     (dn_dev),
    .dn_fn      (dn_fn),
    .dn_reg     (dn_reg),
    .dn_wdata   (dn_wdata),
    .dn_ready   (dn_ready),
    .cfg_en     (cfg_en)
);

// File: tb/tb_cfg_access_port.sv
module tb_cfg_access_port;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0;
    logic          cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [31:0]   cpu_wdata = '0;
    logic          cpu_ready, cpu_rvalid;
    logic [31:0]   cpu_rdata;
    logic          dn_valid, dn_we;
    logic [7:0]    dn_bus;
    logic [4:0]    dn_dev;
    logic [2:0]    dn_fn;
    logic [5:0]    dn_reg;
    logic [31:0]   dn_wdata;
    logic          dn_ready = 1'b0;
    logic [31:0]   dn_rdata = '0;

    int checks = 0;
    int errors = 0;
    int lat = 1;
    int dn_count = 0;
    logic [31:0] mem [64];
    logic        rec_we;
    logic [7:0]  rec_bus;
    logic [4:0]  rec_dev;
    logic [2:0]  rec_fn;
    logic [5:0]  rec_reg;
    logic [31:0] rec_wdata;

    always #4 clk = ~clk;

    cfg_access_port dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
        .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata), .dn_valid(dn_valid),
        .dn_we(dn_we), .dn_bus(dn_bus), .dn_dev(dn_dev), .dn_fn(dn_fn),
        .dn_reg(dn_reg), .dn_wdata(dn_wdata), .dn_ready(dn_ready),
        .dn_rdata(dn_rdata)
    );

    function automatic logic [31:0] sw(input logic [31:0] x);
        return {x[7:0], x[15:8], x[23:16], x[31:24]};
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // configuration fabric model
    initial begin
        int waited = 0;
        for (int i = 0; i < 64; i++) mem[i] = 32'ha500_0000 | i;
        forever begin
            @(negedge clk);
            if (dn_ready) begin
                dn_ready = 1'b0;
                waited = 0;
            end
            if (dn_valid) begin
                waited++;
                if (waited >= lat) begin
                    rec_we = dn_we; rec_bus = dn_bus; rec_dev = dn_dev;
                    rec_fn = dn_fn; rec_reg = dn_reg; rec_wdata = dn_wdata;
                    dn_rdata = mem[dn_reg];
                    if (dn_we) mem[dn_reg] = dn_wdata;
                    dn_ready = 1'b1;
                    dn_count++;
                end else begin
                    chk("R7 cpu_ready low while waiting", {31'b0, cpu_ready}, 32'd0);
                end
            end
        end
    end

    task automatic cpu_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
        while (!cpu_ready) @(negedge clk);
    endtask

    task automatic cpu_read(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
        @(negedge clk);
        cpu_req = 1'b0;
        while (!cpu_rvalid) @(negedge clk);
        d = cpu_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R2 cpu_ready", {31'b0, cpu_ready}, 32'd1);
        chk("R2 dn_valid", {31'b0, dn_valid}, 32'd0);
        chk("R2 cpu_rvalid", {31'b0, cpu_rvalid}, 32'd0);
        cpu_read(0, v); chk("R2 target reads zero", v, 32'h0);
        cpu_read(2, v); chk("R2 control reads zero", v, 32'h0);
    endtask

    task automatic t_disabled();
        logic [31:0] v;
        int n0 = dn_count;
        cpu_read(1, v); chk("R4 disabled window read", v, 32'hffff_ffff);
        chk("R4 no downstream access", dn_count, n0);
        cpu_write(1, 32'h1234_5678);
        repeat (3) @(negedge clk);
        chk("R5 disabled write dropped", dn_count, n0);
    endtask

    task automatic t_flush();
        logic [31:0] v;
        cpu_read(3, v); chk("R8 flush value reversed", v, 32'heeff_00c0);
        cpu_write(3, 32'h0);
        cpu_read(3, v); chk("R8 flush write ignored", v, 32'heeff_00c0);
    endtask

    task automatic t_ctrl();
        logic [31:0] v;
        cpu_write(2, 32'h0000_0001);
        cpu_read(2, v); chk("R3 reversed write leaves bit0 clear", v, 32'h0);
        cpu_write(2, 32'h0100_0000);
        cpu_read(2, v); chk("R3 control bit0 set", v, 32'h1);
        cpu_read(3, v); chk("R8 flush value native", v, 32'hc000_ffee);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        int n0;
        cpu_write(0, 32'hffff_ffff);
        cpu_read(0, v); chk("R1 target mask all ones", v, 32'h80ff_fffc);
        cpu_write(0, 32'h7f5a_9db3);
        cpu_read(0, v); chk("R1 target mask enable clear", v, 32'h005a_9db0);
        n0 = dn_count;
        cpu_write(1, 32'h0000_0055);
        repeat (3) @(negedge clk);
        chk("R5 no downstream on disabled write", dn_count, n0);
        cpu_write(0, 32'h805a_9db0);
        cpu_read(1, v); chk("R5 contents unchanged", v, 32'ha500_002c);
        chk("R6 bus field", {24'b0, rec_bus}, 32'h5a);
        chk("R6 dev field", {27'b0, rec_dev}, 32'h13);
        chk("R6 fn field", {29'b0, rec_fn}, 32'h5);
        chk("R6 reg field", {26'b0, rec_reg}, 32'h2c);
    endtask

    task automatic t_fabric();
        logic [31:0] v;
        lat = 4;
        cpu_write(1, 32'hdead_beef);
        chk("R7 write request type", {31'b0, rec_we}, 32'd1);
        chk("R6 write data forwarded", rec_wdata, 32'hdead_beef);
        cpu_read(1, v); chk("R7 read after stall", v, 32'hdead_beef);
        chk("R7 read request type", {31'b0, rec_we}, 32'd0);
        lat = 1;
    endtask

    task automatic t_swap();
        logic [31:0] v;
        cpu_write(2, 32'h0);
        cpu_write(0, sw(32'h8001_fffc));
        cpu_read(0, v); chk("R3 target read reversed", v, sw(32'h8001_fffc));
        cpu_write(1, 32'h1122_3344);
        chk("R3 downstream write reversed", rec_wdata, 32'h4433_2211);
        chk("R6 max device", {27'b0, rec_dev}, 32'h1f);
        chk("R6 max function", {29'b0, rec_fn}, 32'h7);
        chk("R6 max register", {26'b0, rec_reg}, 32'h3f);
        cpu_read(1, v); chk("R3 downstream read reversed", v, 32'h1122_3344);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_flush();
        t_ctrl();
        t_mask();
        t_fabric();
        t_swap();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end
endmodule